// File: doc/BRIEF.md
# Operand Register Bank with Constant Entries

This block holds the working registers of a small processor core. It has eight entries, each 16 bits wide. Two operand ports read the bank with no clock delay. A single write port stores one result per clock on the rising edge, but only when its enable is high.

Two entries hold no storage. Entry 0 always returns zero, and entry 7 always returns all ones, so the instruction stream has both constants at hand without loading them first. Writes aimed at either constant entry are dropped with no effect. The six entries in between are ordinary storage and are cleared by a synchronous, active-high reset.

A read of an entry in the same cycle as a write to that entry returns the value held before the write. The bank does no bypassing.

Top module: `opnd_reg_bank`

## Requirements
- R1: The bank has eight entries addressed by 3-bit indices 0 to 7, each 16 bits wide, and every index can be read on either port.
- R2: Index 0 reads as 16'h0000 on both read ports at all times.
- R3: Index 7 reads as 16'hFFFF on both read ports at all times, including the first cycle after reset.
- R4: A write with destination index 0 or 7 changes no entry of the bank.
- R5: After a synchronous reset (rst high at a rising edge), indices 1 to 6 read 16'h0000.
- R6: With wr_en high at a rising edge and wr_idx in 1..6, wr_data is returned for that index on both ports from the following cycle.
- R7: A read of an index in the same cycle as a write to it returns the previous contents.
- R8: With wr_en low at a rising edge, no entry changes, whatever wr_idx and wr_data hold.
- R9: The two read ports are independent: each returns the entry its own index selects in the same cycle.
- R10: Reset takes priority over a write in the same cycle: the written entry reads 16'h0000 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 3 | Index for read port A |
| rd_a_data | output | 16 | Contents selected by rd_a_idx |
| rd_b_idx | input | 3 | Index for read port B |
| rd_b_data | output | 16 | Contents selected by rd_b_idx |
| wr_en | input | 1 | Write enable, sampled on the rising edge |
| wr_idx | input | 3 | Write destination index |
| wr_data | input | 16 | Value to store |

## Verification
The bench writes non-zero patterns to entries 0 and 7 and then reads back all eight entries. A bank that stored into a constant slot, or wrote to a neighbouring entry, shows up as a wrong constant or a corrupted entry. Each read is sampled in the same cycle as its write. A design that bypassed the new value, or took an extra cycle to show it, fails those reads. Both ports read different indices in the same cycle, so a shared or crossed select shows up. A write is also issued while reset is high, so a design that lets the write win over reset leaves a non-zero entry behind.

// File: rtl/opnd_reg_bank.sv
module opnd_reg_bank #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(NUM_REGS)-1:0] rd_a_idx,
  output logic [DATA_W-1:0]           rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0] rd_b_idx,
  output logic [DATA_W-1:0]           rd_b_data,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_idx,
  input  logic [DATA_W-1:0]           wr_data
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int TOP   = NUM_REGS - 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TOP);

  logic [DATA_W-1:0] slot [NUM_REGS];

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
      if (k == 0) begin : g_zero
        assign slot[k] = '0;
      end else if (k == TOP) begin : g_ones
        assign slot[k] = '1;
      end else begin : g_store
        always_ff @(posedge clk) begin
          if (rst)
            slot[k] <= '0;
          else if (wr_en && wr_idx == IDX_W'(k))
            slot[k] <= wr_data;
        end
      end
    end
  endgenerate

  assign rd_a_data = slot[rd_a_idx];
  assign rd_b_data = slot[rd_b_idx];

  // R2: index 0 returns zero on both ports
  p_zero_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == '0) |-> (rd_a_data == '0 && (rd_b_idx != '0 || rd_b_data == '0)));

  // R3: top index returns all ones
  p_ones_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == TOP_IDX) |-> (rd_b_data == '1));

  // R6: a write to a storage entry is visible on port A in the next cycle
  p_write_seen_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && $past(wr_idx) != '0 && $past(wr_idx) != TOP_IDX
     && rd_a_idx == $past(wr_idx)) |-> (rd_a_data == $past(wr_data)));

  // R5: storage entries read zero in the first cycle after reset
  p_reset_clear_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd_a_idx != TOP_IDX) |-> (rd_a_data == '0));

  // R8: port B unchanged across a cycle with no write and a steady index
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $stable(rd_b_idx)) |-> $stable(rd_b_data));

endmodule

// File: tb/opnd_reg_bank_tb_top.sv
module opnd_reg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [15:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  opnd_reg_bank dut_i (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // row: we, widx, wdata, ra, rb, expected A, expected B (values before the write lands)
  localparam logic [57:0] VEC [11] = '{
    {1'b1, 3'd1, 16'h1234, 3'd1, 3'd0, 16'h0000, 16'h0000},
    {1'b1, 3'd2, 16'hABCD, 3'd1, 3'd7, 16'h1234, 16'hFFFF},
    {1'b1, 3'd0, 16'h5555, 3'd2, 3'd1, 16'hABCD, 16'h1234},
    {1'b1, 3'd7, 16'h0000, 3'd0, 3'd2, 16'h0000, 16'hABCD},
    {1'b0, 3'd3, 16'h9999, 3'd7, 3'd0, 16'hFFFF, 16'h0000},
    {1'b1, 3'd6, 16'h8001, 3'd3, 3'd6, 16'h0000, 16'h0000},
    {1'b1, 3'd1, 16'h0F0F, 3'd6, 3'd1, 16'h8001, 16'h1234},
    {1'b0, 3'd0, 16'h0000, 3'd1, 3'd6, 16'h0F0F, 16'h8001},
    {1'b1, 3'd4, 16'h00FF, 3'd4, 3'd4, 16'h0000, 16'h0000},
    {1'b1, 3'd5, 16'hFF00, 3'd4, 3'd5, 16'h00FF, 16'h0000},
    {1'b0, 3'd0, 16'h0000, 3'd5, 3'd3, 16'hFF00, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] wi, input logic [15:0] wd);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic read_pair(input logic [2:0] a, input logic [2:0] b);
    @(negedge clk);
    rd_a_idx = a; rd_b_idx = b;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R5 / R3 / R2 / R1: reset state of every index on both ports
    for (int i = 0; i < 8; i++) begin
      read_pair(3'(i), 3'(7 - i));
      check(i == 7 ? "R3 reset A" : (i == 0 ? "R2 reset A" : "R5 reset A"),
            rd_a_data, i == 7 ? 16'hFFFF : 16'h0000);
      check(i == 0 ? "R3 reset B" : (i == 7 ? "R2 reset B" : "R1 reset B"),
            rd_b_data, i == 0 ? 16'hFFFF : 16'h0000);
    end

    // R6 / R7 / R9 / R8 / R4: vector table, reads checked in the write cycle
    for (int v = 0; v < 11; v++) begin
      @(negedge clk);
      {wr_en, wr_idx, wr_data, rd_a_idx, rd_b_idx} = VEC[v][57:32];
      #1;
      check($sformatf("R7 R9 row %0d port A", v), rd_a_data, VEC[v][31:16]);
      check($sformatf("R7 R9 row %0d port B", v), rd_b_data, VEC[v][15:0]);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
    end

    // R4: constant-slot writes with live data leave every entry intact
    step(1'b1, 3'd0, 16'hDEAD);
    step(1'b1, 3'd7, 16'h1357);
    read_pair(3'd0, 3'd7);
    check("R4 idx0", rd_a_data, 16'h0000);
    check("R4 idx7", rd_b_data, 16'hFFFF);
    read_pair(3'd1, 3'd2);
    check("R4 idx1", rd_a_data, 16'h0F0F);
    check("R4 idx2", rd_b_data, 16'hABCD);
    read_pair(3'd3, 3'd6);
    check("R4 idx3", rd_a_data, 16'h0000);
    check("R4 idx6", rd_b_data, 16'h8001);

    // R8: enable low with a storage index does nothing
    step(1'b0, 3'd2, 16'h7777);
    read_pair(3'd2, 3'd2);
    check("R8 disabled write", rd_a_data, 16'hABCD);

    // R6: new value on both ports next cycle
    step(1'b1, 3'd3, 16'h4242);
    read_pair(3'd3, 3'd3);
    check("R6 port A", rd_a_data, 16'h4242);
    check("R6 port B", rd_b_data, 16'h4242);

    // R10: reset beats a same-cycle write; R5: storage cleared
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_idx = 3'd2; wr_data = 16'hBEEF;
    @(posedge clk);
    #1;
    rst = 1'b0; wr_en = 1'b0;
    read_pair(3'd2, 3'd7);
    check("R10 write under reset", rd_a_data, 16'h0000);
    check("R3 after second reset", rd_b_data, 16'hFFFF);
    for (int i = 1; i < 7; i++) begin
      read_pair(3'(i), 3'd0);
      check("R5 cleared", rd_a_data, 16'h0000);
      check("R2 port B", rd_b_data, 16'h0000);
    end

    finish_run();
  end
endmodule